// File: doc/BRIEF.md
# Dual Register File with Rollback

This block keeps two copies of the integer register state. The speculative copy is what the operand stage reads. Completing instructions write it at writeback, in whatever order they finish. The committed copy changes only when an instruction retires, in program order. Operand reads never consult it.

When an exception, an interrupt or a branch mispredict calls for recovery, one rollback request restores the speculative copy. Every committed register is copied over its speculative twin in a single clock edge. The pipeline can then issue from correct state on the very next cycle. A retirement that arrives in the same cycle as the rollback is folded into the copy. A writeback in that cycle is discarded.

Top module: `dual_rf_rollback`

## Requirements
- R1: After the asynchronous reset, every register in both copies holds zero.
- R2: Register 0 always reads as zero. Writes to register 0 on either port are ignored in both copies.
- R3: Two read ports, A and B, each return the speculative value of their own address combinationally and independently.
- R4: A writeback sets the addressed speculative register, and the value is visible from the next cycle on. When one register is written several times, the last write holds, regardless of the order in which the writes arrive.
- R5: A read of the register that a writeback targets in the same cycle returns the writeback data.
- R6: A commit write changes only the committed copy. Speculative reads are unaffected by it.
- R7: A rollback replaces every speculative register with its committed value in one cycle. Reads from the next cycle on return the committed values.
- R8: A writeback in the same cycle as a rollback is dropped.
- R9: A commit write in the same cycle as a rollback is part of the restored state.
- R10: During the rollback cycle itself, the read ports return the values being restored, including a same-cycle commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_addr_a_i | input | 5 | Read port A address |
| rd_data_a_o | output | 32 | Read port A data |
| rd_addr_b_i | input | 5 | Read port B address |
| rd_data_b_o | output | 32 | Read port B data |
| wb_en_i | input | 1 | Writeback enable (speculative copy) |
| wb_addr_i | input | 5 | Writeback register |
| wb_data_i | input | 32 | Writeback data |
| cm_en_i | input | 1 | Commit enable (committed copy) |
| cm_addr_i | input | 5 | Commit register |
| cm_data_i | input | 32 | Commit data |
| rollback_i | input | 1 | Restore speculative copy from committed copy |

## Verification
The committed copy has no read port of its own, so a bad committed entry stays hidden until the next rollback. At that point it shows up on a read port in the rollback cycle itself, because reads bypass the value being restored. It stays visible on every following read of that register. A wrong speculative entry shows up on the first read of that address, one cycle after the faulty write. Each test sequence therefore retires values, then rolls back, and then reads both the registers that were committed and the registers whose writebacks were dropped.

// File: rtl/dual_rf_pkg.sv
package dual_rf_pkg;
  localparam int unsigned RF_NREGS = 32;
  localparam int unsigned RF_DW    = 32;
  localparam int unsigned RF_AW    = $clog2(RF_NREGS);
endpackage

// File: rtl/rf_commit_file.sv
module rf_commit_file #(
  parameter int unsigned NREGS = dual_rf_pkg::RF_NREGS,
  parameter int unsigned DW    = dual_rf_pkg::RF_DW,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cm_en_i,
  input  logic [AW-1:0]             cm_addr_i,
  input  logic [DW-1:0]             cm_data_i,
  output logic [NREGS-1:0][DW-1:0]  arch_q_o,
  output logic [NREGS-1:0][DW-1:0]  arch_next_o
);
  logic [NREGS-1:0][DW-1:0] arch_q;

  for (genvar i = 0; i < NREGS; i++) begin : g_next
    if (i == 0) begin : g_zero
      assign arch_next_o[i] = '0;
    end else begin : g_reg
      assign arch_next_o[i] = (cm_en_i && cm_addr_i == AW'(i)) ? cm_data_i : arch_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arch_q <= '0;
    else         arch_q <= arch_next_o;
  end

  assign arch_q_o = arch_q;

  a_r6_commit_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cm_en_i && cm_addr_i != '0 |=> arch_q[$past(cm_addr_i)] == $past(cm_data_i));
  a_r2_arch_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arch_q[0] == '0);
endmodule

// File: rtl/rf_spec_file.sv
module rf_spec_file #(
  parameter int unsigned NREGS = dual_rf_pkg::RF_NREGS,
  parameter int unsigned DW    = dual_rf_pkg::RF_DW,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wb_en_i,
  input  logic [AW-1:0]             wb_addr_i,
  input  logic [DW-1:0]             wb_data_i,
  input  logic                      rollback_i,
  input  logic [NREGS-1:0][DW-1:0]  arch_next_i,
  output logic [NREGS-1:0][DW-1:0]  spec_q_o
);
  logic [NREGS-1:0][DW-1:0] spec_q, spec_d;

  for (genvar i = 0; i < NREGS; i++) begin : g_next
    if (i == 0) begin : g_zero
      assign spec_d[i] = '0;
    end else begin : g_reg
      // rollback has priority over writeback
      always_comb begin
        if (rollback_i)                              spec_d[i] = arch_next_i[i];
        else if (wb_en_i && wb_addr_i == AW'(i))     spec_d[i] = wb_data_i;
        else                                         spec_d[i] = spec_q[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) spec_q <= '0;
    else         spec_q <= spec_d;
  end

  assign spec_q_o = spec_q;

  a_r4_wb_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_i && !rollback_i && wb_addr_i != '0
    |=> spec_q[$past(wb_addr_i)] == $past(wb_data_i));
  a_r8_wb_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rollback_i && wb_en_i
    |=> spec_q[$past(wb_addr_i)] == $past(arch_next_i[wb_addr_i]));
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int unsigned NREGS = dual_rf_pkg::RF_NREGS,
  parameter int unsigned DW    = dual_rf_pkg::RF_DW,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [AW-1:0]             addr_i,
  input  logic [NREGS-1:0][DW-1:0]  spec_q_i,
  input  logic [NREGS-1:0][DW-1:0]  arch_next_i,
  input  logic                      rollback_i,
  input  logic                      wb_en_i,
  input  logic [AW-1:0]             wb_addr_i,
  input  logic [DW-1:0]             wb_data_i,
  output logic [DW-1:0]             data_o
);
  always_comb begin
    if (addr_i == '0)                              data_o = '0;
    else if (rollback_i)                           data_o = arch_next_i[addr_i];
    else if (wb_en_i && wb_addr_i == addr_i)       data_o = wb_data_i;
    else                                           data_o = spec_q_i[addr_i];
  end

  a_r2_zero_reads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == '0 |-> data_o == '0);
endmodule

// File: rtl/dual_rf_rollback.sv
module dual_rf_rollback #(
  parameter int unsigned NREGS = dual_rf_pkg::RF_NREGS,
  parameter int unsigned DW    = dual_rf_pkg::RF_DW,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] rd_addr_a_i,
  output logic [DW-1:0] rd_data_a_o,
  input  logic [AW-1:0] rd_addr_b_i,
  output logic [DW-1:0] rd_data_b_o,
  input  logic          wb_en_i,
  input  logic [AW-1:0] wb_addr_i,
  input  logic [DW-1:0] wb_data_i,
  input  logic          cm_en_i,
  input  logic [AW-1:0] cm_addr_i,
  input  logic [DW-1:0] cm_data_i,
  input  logic          rollback_i
);
  localparam int unsigned NPORTS = 2;

  logic [NREGS-1:0][DW-1:0] arch_q, arch_next, spec_q;
  logic [NPORTS-1:0][AW-1:0] rd_addr;
  logic [NPORTS-1:0][DW-1:0] rd_data;

  rf_commit_file #(.NREGS(NREGS), .DW(DW)) u_commit (
    .clk_i, .rst_ni, .cm_en_i, .cm_addr_i, .cm_data_i,
    .arch_q_o(arch_q), .arch_next_o(arch_next)
  );

  rf_spec_file #(.NREGS(NREGS), .DW(DW)) u_spec (
    .clk_i, .rst_ni, .wb_en_i, .wb_addr_i, .wb_data_i, .rollback_i,
    .arch_next_i(arch_next), .spec_q_o(spec_q)
  );

  assign rd_addr[0] = rd_addr_a_i;
  assign rd_addr[1] = rd_addr_b_i;

  for (genvar p = 0; p < NPORTS; p++) begin : g_rd
    rf_read_port #(.NREGS(NREGS), .DW(DW)) u_rd (
      .clk_i, .rst_ni, .addr_i(rd_addr[p]), .spec_q_i(spec_q),
      .arch_next_i(arch_next), .rollback_i, .wb_en_i, .wb_addr_i,
      .wb_data_i, .data_o(rd_data[p])
    );
  end

  assign rd_data_a_o = rd_data[0];
  assign rd_data_b_o = rd_data[1];

  // after a rollback, with no new write in between, reads match committed state
  a_r7_restore_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rollback_i) && !rollback_i && !wb_en_i |-> rd_data_a_o == arch_q[rd_addr_a_i]);
  a_r9_commit_in_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rollback_i && cm_en_i && cm_addr_i != '0 |=> spec_q[$past(cm_addr_i)] == $past(cm_data_i));
endmodule

// File: tb/dual_rf_rollback_tb.sv
module dual_rf_rollback_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;

  typedef struct packed {
    logic        wb_en; logic [4:0] wb_a; logic [31:0] wb_d;
    logic        cm_en; logic [4:0] cm_a; logic [31:0] cm_d;
    logic        rbk;   logic [4:0] ra;   logic [4:0]  rb;
    logic [31:0] exp_a; logic [31:0] exp_b; logic [7:0] req;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b1,5'd1,32'hAAAA, 1'b0,5'd0,32'h0,    1'b0, 5'd1,5'd2, 32'hAAAA,32'h0,    8'd5},  // R5 bypass
    '{1'b1,5'd2,32'hBBBB, 1'b0,5'd0,32'h0,    1'b0, 5'd1,5'd2, 32'hAAAA,32'hBBBB, 8'd4},  // R4 R3
    '{1'b0,5'd0,32'h0,    1'b1,5'd1,32'h1111, 1'b0, 5'd1,5'd0, 32'hAAAA,32'h0,    8'd6},  // R6
    '{1'b1,5'd0,32'hDEAD, 1'b0,5'd0,32'h0,    1'b0, 5'd0,5'd2, 32'h0,   32'hBBBB, 8'd2},  // R2 wb r0
    '{1'b0,5'd0,32'h0,    1'b1,5'd0,32'h5555, 1'b0, 5'd0,5'd1, 32'h0,   32'hAAAA, 8'd6},  // R6 R2
    '{1'b1,5'd3,32'h3333, 1'b1,5'd2,32'h2222, 1'b1, 5'd1,5'd2, 32'h1111,32'h2222, 8'd10}, // R10 R9
    '{1'b0,5'd0,32'h0,    1'b0,5'd0,32'h0,    1'b0, 5'd3,5'd1, 32'h0,   32'h1111, 8'd8},  // R8 R7
    '{1'b0,5'd0,32'h0,    1'b0,5'd0,32'h0,    1'b0, 5'd2,5'd0, 32'h2222,32'h0,    8'd9},  // R9
    '{1'b1,5'd3,32'h7777, 1'b1,5'd3,32'h9999, 1'b0, 5'd3,5'd3, 32'h7777,32'h7777, 8'd5},  // R5 R6
    '{1'b0,5'd0,32'h0,    1'b0,5'd0,32'h0,    1'b1, 5'd3,5'd2, 32'h9999,32'h2222, 8'd10}, // R10
    '{1'b0,5'd0,32'h0,    1'b0,5'd0,32'h0,    1'b0, 5'd3,5'd1, 32'h9999,32'h1111, 8'd7}   // R7
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [4:0] rd_addr_a, rd_addr_b, wb_addr, cm_addr;
  logic [31:0] rd_data_a, rd_data_b, wb_data, cm_data;
  logic wb_en, cm_en, rollback;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_rf_rollback u_dut (
    .clk_i(clk), .rst_ni, .rd_addr_a_i(rd_addr_a), .rd_data_a_o(rd_data_a),
    .rd_addr_b_i(rd_addr_b), .rd_data_b_o(rd_data_b),
    .wb_en_i(wb_en), .wb_addr_i(wb_addr), .wb_data_i(wb_data),
    .cm_en_i(cm_en), .cm_addr_i(cm_addr), .cm_data_i(cm_data), .rollback_i(rollback)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic we, input logic [4:0] wa, input logic [31:0] wd,
                       input logic ce, input logic [4:0] ca, input logic [31:0] cd,
                       input logic rbk, input logic [4:0] ra, input logic [4:0] rb);
    @(negedge clk);
    wb_en = we; wb_addr = wa; wb_data = wd;
    cm_en = ce; cm_addr = ca; cm_data = cd;
    rollback = rbk; rd_addr_a = ra; rd_addr_b = rb;
    #1;
  endtask

  task automatic idle_read(input logic [4:0] ra, input logic [4:0] rb);
    drive(1'b0, 5'd0, 32'h0, 1'b0, 5'd0, 32'h0, 1'b0, ra, rb);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    wb_en = 0; wb_addr = 0; wb_data = 0; cm_en = 0; cm_addr = 0; cm_data = 0;
    rollback = 0; rd_addr_a = 0; rd_addr_b = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state visible on both ports
    idle_read(5'd5, 5'd31);
    check("R1 port A", rd_data_a, 32'h0);
    check("R1 port B", rd_data_b, 32'h0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].wb_en, VECS[i].wb_a, VECS[i].wb_d, VECS[i].cm_en, VECS[i].cm_a,
            VECS[i].cm_d, VECS[i].rbk, VECS[i].ra, VECS[i].rb);
      check($sformatf("R%0d vec%0d A", VECS[i].req, i), rd_data_a, VECS[i].exp_a);
      check($sformatf("R%0d vec%0d B", VECS[i].req, i), rd_data_b, VECS[i].exp_b);
    end

    // R4 out-of-order writebacks to the same register: last one holds
    drive(1'b1, 5'd31, 32'h0000_00A1, 1'b0, 5'd0, 32'h0, 1'b0, 5'd0, 5'd0);
    drive(1'b1, 5'd31, 32'h0000_00B2, 1'b0, 5'd0, 32'h0, 1'b0, 5'd0, 5'd0);
    idle_read(5'd31, 5'd31);
    check("R4 last write r31", rd_data_a, 32'h0000_00B2);

    // R7 boundary register restored from committed copy
    drive(1'b0, 5'd0, 32'h0, 1'b1, 5'd31, 32'hFFFF_FFFF, 1'b0, 5'd0, 5'd0);
    idle_read(5'd31, 5'd0);
    check("R6 commit hidden r31", rd_data_a, 32'h0000_00B2);
    drive(1'b0, 5'd0, 32'h0, 1'b0, 5'd0, 32'h0, 1'b1, 5'd0, 5'd0);
    idle_read(5'd31, 5'd3);
    check("R7 restore r31", rd_data_a, 32'hFFFF_FFFF);
    check("R7 restore r3", rd_data_b, 32'h9999);

    // R1 reset again clears both copies
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    idle_read(5'd31, 5'd1);
    check("R1 spec after reset", rd_data_a, 32'h0);
    drive(1'b0, 5'd0, 32'h0, 1'b0, 5'd0, 32'h0, 1'b1, 5'd0, 5'd0);
    idle_read(5'd31, 5'd1);
    check("R1 arch after reset r31", rd_data_a, 32'h0);
    check("R1 arch after reset r1", rd_data_b, 32'h0);

    finish_run();
  end
endmodule